// File: doc/BRIEF.md
# Display Self-Test Sequencer

This block runs the built-in self-test of a dot-matrix character display controller. A one-cycle start request, raised when the host writes the self-test bit of the control word, begins a run of fixed length. During that run the host interface must stay quiet. The run has three phases in order.

In the first phase the block walks the character-font ROM through every row of every character code and adds up the dot rows it reads back. The sum is compared with a constant given as a parameter, and the result becomes the read-only pass bit of the control word. In the second and third phases the block takes over the dot drivers. It shows a checkerboard and then its inverse, so that every LED is lit once.

On the last cycle of the run the block pulses the restore strobes. These load blanks into the character RAM, clear the flash RAM, set the custom-glyph address register to all ones, and load the control word with zero except for the pass bit. The whole run lasts `TOTAL` clocks, which is 262,144 by default. Each display phase is `TOTAL/2 - WALK/2` clocks long, where `WALK = CODES*ROWS` is the length of the ROM walk.

Top module: `self_test_seq`

## Requirements
- R1: A start request sampled while idle raises busy_o on the next cycle. busy_o then stays high for exactly TOTAL cycles, numbered t=0 to t=TOTAL-1, and falls afterwards.
- R2: A start request sampled while busy, including on the final cycle t=TOTAL-1, has no effect on the sequence or on its length.
- R3: On cycles t=0 to t=WALK-1, rom_addr_o equals {code, row}. The row sits in the low $clog2(ROWS) bits and the code in the bits above it. The row counts 0 to ROWS-1 inside each code, and the code counts up from 0. At all other times, and while idle, rom_addr_o is 0.
- R4: ROM data is taken one cycle after its address. result_o is 1 exactly when the sum of all WALK rows, taken modulo 2^CHK_W, equals EXPECTED. The new value is visible from t=WALK+1 and is held, including while idle, until the next start.
- R5: result_o reads 0 from t=0 of every run until the new verdict appears.
- R6: On cycles t=WALK to t=WALK+PHASE-1, pat_en_o=1 and pat_inv_o=0. Bit b of pat_dots_o is lit when b+pat_row_i is even.
- R7: On cycles t=WALK+PHASE to t=TOTAL-1, pat_en_o=1 and pat_inv_o=1. Bit b of pat_dots_o is lit when b+pat_row_i is odd.
- R8: Outside the two display phases, pat_en_o and pat_inv_o are 0 and pat_dots_o is 0.
- R9: Each display phase lasts PHASE = TOTAL/2 - WALK/2 cycles.
- R10: blank_chars_o, clear_flash_o, udc_fill_o and ctrl_load_o pulse together for one cycle, at t=TOTAL-1 only. ctrl_val_o is always zero except bit 5, which equals result_o.
- R11: While reset is held and after its release, busy_o, result_o, rom_addr_o, pat_en_o and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Self-test start request |
| rom_data_i | input | DOT_W | Font ROM row read back, one cycle after its address |
| pat_row_i | input | $clog2(ROWS) | Row currently scanned by the drivers |
| busy_o | output | 1 | Test in progress |
| rom_addr_o | output | $clog2(CODES)+$clog2(ROWS) | Font ROM address {code,row} |
| result_o | output | 1 | Pass bit |
| pat_en_o | output | 1 | Pattern override active |
| pat_inv_o | output | 1 | Inverse pattern phase |
| pat_dots_o | output | DOT_W | Override dots for the scanned row |
| blank_chars_o | output | 1 | Load blanks into the character RAM |
| clear_flash_o | output | 1 | Clear the flash RAM |
| udc_fill_o | output | 1 | Set the custom-glyph address register to all ones |
| ctrl_load_o | output | 1 | Load ctrl_val_o into the control word |
| ctrl_val_o | output | CTRL_W | Control word restore value |

## Verification
The bench works with a corrupted ROM entry and an intact one in turn. A design that drops the last ROM row, or samples the data in the same cycle as its address, passes the corrupted ROM or fails the intact one. Start requests placed in the middle of the walk and on the very last cycle show whether the block restarts or stretches the run; that would appear as an address that jumps back or a busy signal that stays high too long. With start held high, runs follow one another back to back, which exposes a pass bit that is not cleared at the start of a run. The display-phase cycles are counted, which catches an off-by-one at either phase boundary or a pattern that is not inverted on alternate rows.

// File: rtl/st_pkg.sv
package st_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WALK = 2'd1,
    PH_SHOW = 2'd2,
    PH_INV  = 2'd3
  } st_phase_e;
endpackage

// File: rtl/st_timer.sv
module st_timer
  import st_pkg::*;
#(
  parameter int TOTAL = 262144,
  parameter int WALK  = 896,
  parameter int PHASE = 130624
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  output logic      busy_o,
  output logic      start_acc_o,
  output logic      walk_last_o,
  output logic      end_o,
  output st_phase_e phase_o
);
  localparam int CNT_W = $clog2(TOTAL);
  localparam logic [CNT_W-1:0] LAST      = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] WALK_END  = CNT_W'(WALK);
  localparam logic [CNT_W-1:0] WALK_LAST = CNT_W'(WALK - 1);
  localparam logic [CNT_W-1:0] INV_START = CNT_W'(WALK + PHASE);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign start_acc_o = start_i & ~busy_q;
  assign end_o       = busy_q & (cnt_q == LAST);
  assign walk_last_o = busy_q & (cnt_q == WALK_LAST);
  assign busy_o      = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_acc_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (end_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (!busy_q)                phase_o = PH_IDLE;
    else if (cnt_q < WALK_END)  phase_o = PH_WALK;
    else if (cnt_q < INV_START) phase_o = PH_SHOW;
    else                        phase_o = PH_INV;
  end
endmodule

// File: rtl/st_walk.sv
module st_walk #(
  parameter int              CODES    = 128,
  parameter int              ROWS     = 7,
  parameter int              DOT_W    = 5,
  parameter int              CHK_W    = 16,
  parameter logic [CHK_W-1:0] EXPECTED = '0,
  localparam int             CODE_W   = $clog2(CODES),
  localparam int             ROW_W    = $clog2(ROWS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    walk_i,
  input  logic                    last_i,
  input  logic [DOT_W-1:0]        rom_data_i,
  output logic [CODE_W+ROW_W-1:0] rom_addr_o,
  output logic                    pass_o
);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(ROWS - 1);

  logic [CODE_W-1:0] code_q;
  logic [ROW_W-1:0]  row_q;
  logic              vld_q, last_q, pass_q;
  logic [CHK_W-1:0]  acc_q, sum_d;

  assign rom_addr_o = walk_i ? {code_q, row_q} : '0;
  assign sum_d      = acc_q + CHK_W'(rom_data_i);
  assign pass_o     = pass_q;

  // address walk: row minor, code major
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      row_q  <= '0;
    end else if (clr_i) begin
      code_q <= '0;
      row_q  <= '0;
    end else if (walk_i) begin
      if (row_q == ROW_MAX) begin
        row_q  <= '0;
        code_q <= code_q + 1'b1;
      end else begin
        row_q <= row_q + 1'b1;
      end
    end
  end

  // data returns one cycle after its address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      acc_q  <= '0;
      pass_q <= 1'b0;
    end else begin
      vld_q  <= walk_i & ~clr_i;
      last_q <= walk_i & last_i & ~clr_i;
      if (clr_i) begin
        acc_q  <= '0;
        pass_q <= 1'b0;
      end else if (vld_q) begin
        acc_q <= sum_d;
        if (last_q) pass_q <= (sum_d == EXPECTED);
      end
    end
  end
endmodule

// File: rtl/st_pattern.sv
module st_pattern #(
  parameter int DOT_W = 5,
  parameter int ROW_W = 3
) (
  input  logic             show_i,
  input  logic             inv_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [DOT_W-1:0] dots_o
);
  for (genvar b = 0; b < DOT_W; b++) begin : g_col
    localparam logic ODD = 1'(b % 2);
    assign dots_o[b] = show_i & ~(ODD ^ row_i[0] ^ inv_i);
  end
endmodule

// File: rtl/self_test_seq.sv
module self_test_seq
  import st_pkg::*;
#(
  parameter int               CODES    = 128,
  parameter int               ROWS     = 7,
  parameter int               DOT_W    = 5,
  parameter int               CHK_W    = 16,
  parameter logic [CHK_W-1:0] EXPECTED = 16'hA5C3,
  parameter int               TOTAL    = 262144,
  parameter int               CTRL_W   = 8,
  parameter int               RES_BIT  = 5,
  localparam int              CODE_W   = $clog2(CODES),
  localparam int              ROW_W    = $clog2(ROWS),
  localparam int              ADDR_W   = CODE_W + ROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DOT_W-1:0]  rom_data_i,
  input  logic [ROW_W-1:0]  pat_row_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              result_o,
  output logic              pat_en_o,
  output logic              pat_inv_o,
  output logic [DOT_W-1:0]  pat_dots_o,
  output logic              blank_chars_o,
  output logic              clear_flash_o,
  output logic              udc_fill_o,
  output logic              ctrl_load_o,
  output logic [CTRL_W-1:0] ctrl_val_o
);
  localparam int WALK  = CODES * ROWS;
  localparam int PHASE = TOTAL / 2 - WALK / 2;

  st_phase_e phase;
  logic      start_acc, walk_last, run_end, show, inv;

  st_timer #(.TOTAL(TOTAL), .WALK(WALK), .PHASE(PHASE)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .start_acc_o (start_acc),
    .walk_last_o (walk_last),
    .end_o       (run_end),
    .phase_o     (phase)
  );

  st_walk #(
    .CODES(CODES), .ROWS(ROWS), .DOT_W(DOT_W),
    .CHK_W(CHK_W), .EXPECTED(EXPECTED)
  ) u_walk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_acc),
    .walk_i     (phase == PH_WALK),
    .last_i     (walk_last),
    .rom_data_i (rom_data_i),
    .rom_addr_o (rom_addr_o),
    .pass_o     (result_o)
  );

  assign show = (phase == PH_SHOW) | (phase == PH_INV);
  assign inv  = (phase == PH_INV);

  st_pattern #(.DOT_W(DOT_W), .ROW_W(ROW_W)) u_pat (
    .show_i (show),
    .inv_i  (inv),
    .row_i  (pat_row_i),
    .dots_o (pat_dots_o)
  );

  assign pat_en_o      = show;
  assign pat_inv_o     = inv;
  assign blank_chars_o = run_end;
  assign clear_flash_o = run_end;
  assign udc_fill_o    = run_end;
  assign ctrl_load_o   = run_end;

  always_comb begin
    ctrl_val_o          = '0;
    ctrl_val_o[RES_BIT] = result_o;
  end
endmodule

// File: rtl/st_checker.sv
module st_checker #(
  parameter int ADDR_W = 10,
  parameter int DOT_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic [ADDR_W-1:0] rom_addr_o,
  input logic              result_o,
  input logic              pat_en_o,
  input logic              pat_inv_o,
  input logic [DOT_W-1:0]  pat_dots_o,
  input logic              blank_chars_o,
  input logic              clear_flash_o,
  input logic              udc_fill_o,
  input logic              ctrl_load_o
);
  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o); // R1
  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_load_o |=> !busy_o); // R1
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !ctrl_load_o |=> busy_o); // R2
  AST_ADDR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> rom_addr_o == '0); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(result_o)); // R4
  AST_RESULT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> !result_o); // R5
  AST_INV_IN_SHOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_inv_o |-> pat_en_o); // R7
  AST_DOTS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pat_en_o |-> pat_dots_o == '0); // R8
  AST_PAT_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_en_o |-> busy_o); // R8
  AST_STROBE_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({blank_chars_o, clear_flash_o, udc_fill_o, ctrl_load_o}) == 0 ||
    $countones({blank_chars_o, clear_flash_o, udc_fill_o, ctrl_load_o}) == 4); // R10
  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_load_o |=> !ctrl_load_o); // R10
endmodule

bind self_test_seq st_checker #(.ADDR_W(ADDR_W), .DOT_W(DOT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .rom_addr_o    (rom_addr_o),
  .result_o      (result_o),
  .pat_en_o      (pat_en_o),
  .pat_inv_o     (pat_inv_o),
  .pat_dots_o    (pat_dots_o),
  .blank_chars_o (blank_chars_o),
  .clear_flash_o (clear_flash_o),
  .udc_fill_o    (udc_fill_o),
  .ctrl_load_o   (ctrl_load_o)
);

// File: tb/sim_self_test_seq.sv
`timescale 1ns/1ps
module sim_self_test_seq;
  localparam int CODES  = 8;
  localparam int ROWS   = 7;
  localparam int DOT_W  = 5;
  localparam int CHK_W  = 16;
  localparam int TOTAL  = 256;
  localparam int CTRL_W = 8;
  localparam int WALK   = CODES * ROWS;
  localparam int PHASE  = TOTAL / 2 - WALK / 2;
  localparam int ROW_W  = 3;
  localparam int ADDR_W = 6;

  function automatic int rom_fn(input int code, input int row, input bit bad);
    int v;
    v = (code * 7 + row * 3 + 5) % 32;
    if (bad && code == 3 && row == 2) v = v ^ 1;
    return v;
  endfunction

  function automatic int rom_sum(input bit bad);
    int s;
    s = 0;
    for (int c = 0; c < CODES; c++)
      for (int r = 0; r < ROWS; r++) s += rom_fn(c, r, bad);
    return s % 65536;
  endfunction

  localparam int GOLD = rom_sum(1'b0);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic corrupt = 1'b0;
  logic [DOT_W-1:0] rom_q = '0;
  logic [ROW_W-1:0] pat_row = '0;
  logic busy, result, pat_en, pat_inv, blank_s, flash_s, udc_s, ctrl_s;
  logic [ADDR_W-1:0] rom_addr;
  logic [DOT_W-1:0] dots;
  logic [CTRL_W-1:0] ctrl_val;

  always #5 clk = ~clk;

  self_test_seq #(
    .CODES(CODES), .ROWS(ROWS), .DOT_W(DOT_W), .CHK_W(CHK_W),
    .EXPECTED(16'(GOLD)), .TOTAL(TOTAL), .CTRL_W(CTRL_W), .RES_BIT(5)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rom_data_i(rom_q),
    .pat_row_i(pat_row), .busy_o(busy), .rom_addr_o(rom_addr),
    .result_o(result), .pat_en_o(pat_en), .pat_inv_o(pat_inv),
    .pat_dots_o(dots), .blank_chars_o(blank_s), .clear_flash_o(flash_s),
    .udc_fill_o(udc_s), .ctrl_load_o(ctrl_s), .ctrl_val_o(ctrl_val)
  );

  // synchronous ROM model
  always @(posedge clk) rom_q <= DOT_W'(rom_fn(int'(rom_addr) / 8, int'(rom_addr) % 8, corrupt));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model
  bit m_busy = 1'b0, m_res = 1'b0, m_pass = 1'b0;
  int m_t = 0;
  initial forever begin
    @(posedge clk);
    if (!rst_n) begin
      m_busy = 0; m_res = 0; m_t = 0;
    end else if (!m_busy && start) begin
      m_busy = 1; m_t = 0; m_res = 0;
      m_pass = (rom_sum(corrupt) == GOLD);
    end else if (m_busy) begin
      if (m_t == TOTAL - 1) m_busy = 0;
      else begin
        m_t++;
        if (m_t == WALK + 1) m_res = m_pass;
      end
    end
  end

  // per-cycle comparison
  int n_show = 0, n_inv = 0;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      bit walk, show, inv, strb;
      int ea, ed;
      walk = m_busy && m_t < WALK;
      show = m_busy && m_t >= WALK;
      inv  = m_busy && m_t >= WALK + PHASE;
      strb = m_busy && m_t == TOTAL - 1;
      ea = walk ? ((m_t / ROWS) * 8 + m_t % ROWS) : 0;
      ed = 0;
      for (int b = 0; b < DOT_W; b++)
        if (show && ((((b + int'(pat_row)) % 2) == 0) != inv)) ed |= (1 << b);
      if (pat_en && !pat_inv) n_show++;
      if (pat_inv) n_inv++;
      chk(busy == m_busy, "R1", "busy", busy, m_busy);
      chk(int'(rom_addr) == ea, "R3", "rom_addr", rom_addr, ea);
      chk(result == m_res, "R4", "result", result, m_res);
      chk(pat_en == show, "R6", "pat_en", pat_en, show);
      chk(pat_inv == inv, "R7", "pat_inv", pat_inv, inv);
      chk(int'(dots) == ed, show ? "R6" : "R8", "dots", dots, ed);
      chk({blank_s, flash_s, udc_s, ctrl_s} == {4{strb}}, "R10", "strobes",
          {blank_s, flash_s, udc_s, ctrl_s}, strb ? 15 : 0);
      chk(int'(ctrl_val) == (m_res ? 32 : 0), "R10", "ctrl_val", ctrl_val, m_res ? 32 : 0);
      pat_row = (pat_row == ROW_W'(ROWS - 1)) ? '0 : pat_row + 1'b1;
    end
  end

  task automatic wait_t(input int t);
    do @(negedge clk); while (!(m_busy && m_t == t));
  endtask

  task automatic pulse_start;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run;
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !result && rom_addr == '0 && !pat_en && !ctrl_s && !blank_s,
        "R11", "reset outputs", {busy, result, pat_en, ctrl_s}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !result && rom_addr == '0, "R11", "after release", {busy, result}, 0);

    // run 1: intact ROM, starts while busy
    n_show = 0; n_inv = 0;
    @(negedge clk);
    pulse_start();
    wait_t(10);
    pulse_start();
    chk(int'(rom_addr) == (1 * 8 + 4), "R2", "addr after mid-walk start",
        rom_addr, 12);
    wait_t(WALK + 5);
    pulse_start();
    wait_t(TOTAL - 1);
    pulse_start();
    chk(!busy, "R2", "busy after final-cycle start", busy, 0);
    finish_run();
    chk(n_show == PHASE, "R9", "show cycles", n_show, PHASE);
    chk(n_inv == PHASE, "R9", "inverse cycles", n_inv, PHASE);
    chk(result == 1'b1, "R4", "pass with intact ROM", result, 1);

    // run 2: corrupted ROM
    corrupt = 1'b1;
    pulse_start();
    chk(result == 1'b0, "R5", "result cleared at t=0", result, 0);
    finish_run();
    chk(result == 1'b0, "R4", "fail with bad ROM", result, 0);

    // run 3: start held high, back-to-back runs
    corrupt = 1'b0;
    start = 1'b1;
    repeat (2 * TOTAL + 4) @(negedge clk);
    start = 1'b0;
    finish_run();
    repeat (5) @(negedge clk);
    chk(result == 1'b1 && !busy, "R4", "result held while idle", result, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule